// File: doc/BRIEF.md
# Sticky Error Status Register Bank

This block gathers one-cycle error and warning strobes from the sensor's signal-conditioning and conversion logic. It holds them in three 8-bit status bytes that a register-read interface can fetch at three consecutive addresses. Each latched bit remembers that its condition occurred at least once since it was last cleared.

A byte is cleared by reading it. A soft-reset command clears all three bytes at once. There are two exceptions. The startup configuration-error bit survives a soft reset when the fault was a missing nonvolatile memory. The top bit of the third byte is a live busy indicator and is never latched.

Reads are accepted in every operating state. The read data is registered and appears one cycle after the read strobe.

Top module: `err_status_bank`

## Requirements
- R1: The bytes are mapped at BASE (default 0x75), BASE+1 and BASE+2. A read strobe to any other address returns 0x00 and leaves all three bytes unchanged.
- R2: A high bit on an event input sets the matching status bit, active-high (1 = condition seen). The bit stays set until its byte is read, or a soft reset clears it. Bit n of `ev_lo` maps to bit n of BASE (except bit 6), bit n of `ev_mid` to bit n of BASE+1, and bit n of `ev_hi` to bit n (0..6) of BASE+2.
- R3: `rd_data` takes the addressed byte's value as it was before clearing, on the clock edge where `rd_stb` is high. It holds that value until the next read strobe.
- R4: A read clears only the byte it addresses.
- R5: An event that arrives in the same cycle as a clear of its bit, by read or by soft reset, wins: the bit is set afterwards.
- R6: A `soft_rst` pulse clears every latched bit of all three bytes. The only exception is R8.
- R7: Bit 6 of BASE is the configuration-error bit. It is set on every cycle in which `cfg_err` is high, whatever the cause. Bit 6 of `ev_lo` has no effect.
- R8: Once `cfg_err` and `cfg_nomem` have been high together, a soft reset no longer clears bit 6 of BASE. A read still clears it.
- R9: Bit 7 of BASE+2 is the live OR of `busy_bus` and `busy_conv` at the strobe cycle. It is neither latched nor cleared.
- R10: The synchronous reset `rst` clears all latched bits, the no-memory memory of R8, and `rd_data`.
- R11: A read returns valid data and clears its byte even while a busy input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ev_lo | input | 8 | Event strobes for byte BASE (bit 6 unused) |
| ev_mid | input | 8 | Event strobes for byte BASE+1 |
| ev_hi | input | 7 | Event strobes for bits 6..0 of byte BASE+2 |
| cfg_err | input | 1 | Startup configuration error level |
| cfg_nomem | input | 1 | Qualifier: the configuration error was a missing memory |
| soft_rst | input | 1 | Soft-reset command pulse |
| busy_bus | input | 1 | Command using the internal data bus in progress |
| busy_conv | input | 1 | Converter command started or startup phase |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong latched state shows up only through a read. It appears in `rd_data` one cycle after the strobe, or one read later when the fault is a missed clear. For that reason every event pattern is followed by reads of the addressed byte and of its neighbours. The persistent configuration bit and the live busy bit are checked across soft resets and busy phases. Same-cycle collisions of an event with a clear are checked by a second read, which exposes a lost event at once.

// File: rtl/err_status_bank.sv
module err_status_bank #(
  parameter int              AW   = 8,
  parameter logic [AW-1:0]   BASE = 8'h75
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    ev_lo,
  input  logic [7:0]    ev_mid,
  input  logic [6:0]    ev_hi,
  input  logic          cfg_err,
  input  logic          cfg_nomem,
  input  logic          soft_rst,
  input  logic          busy_bus,
  input  logic          busy_conv,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam logic [AW-1:0] A1 = BASE + AW'(1);
  localparam logic [AW-1:0] A2 = BASE + AW'(2);
  localparam int            CFG = 6;

  logic [7:0] st_lo, st_mid;
  logic [6:0] st_hi;
  logic       nomem_q;
  logic [7:0] clr_lo, set_lo;

  wire hit_lo  = rd_stb && (rd_addr == BASE);
  wire hit_mid = rd_stb && (rd_addr == A1);
  wire hit_hi  = rd_stb && (rd_addr == A2);
  wire live    = busy_bus | busy_conv;

  assign set_lo = {ev_lo[7], cfg_err, ev_lo[5:0]};

  always_comb begin
    clr_lo = (hit_lo || soft_rst) ? 8'hFF : 8'h00;
    if (soft_rst && nomem_q && !hit_lo) clr_lo[CFG] = 1'b0;
  end

  wire [7:0] clr_mid = (hit_mid || soft_rst) ? 8'hFF : 8'h00;
  wire [6:0] clr_hi  = (hit_hi  || soft_rst) ? 7'h7F : 7'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_lo   <= '0;
      st_mid  <= '0;
      st_hi   <= '0;
      nomem_q <= 1'b0;
      rd_data <= '0;
    end else begin
      st_lo   <= (st_lo  & ~clr_lo)  | set_lo;
      st_mid  <= (st_mid & ~clr_mid) | ev_mid;
      st_hi   <= (st_hi  & ~clr_hi)  | ev_hi;
      nomem_q <= nomem_q | (cfg_err & cfg_nomem);
      if (rd_stb) begin
        if (hit_lo)       rd_data <= st_lo;
        else if (hit_mid) rd_data <= st_mid;
        else if (hit_hi)  rd_data <= {live, st_hi};
        else              rd_data <= 8'h00;
      end
    end
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_stb) && !$past(rst)) |-> $stable(rd_data));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_mid != 8'h00) |=> ((st_mid & $past(ev_mid)) == $past(ev_mid)));

  // R8
  cfg_persist_chk: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && nomem_q && st_lo[CFG] && !hit_lo) |=> st_lo[CFG]);

  // R9
  live_bit_chk: assert property (@(posedge clk) disable iff (rst)
    hit_hi |=> (rd_data[7] == $past(live)));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && !soft_rst && ev_mid == 8'h00) |=> $stable(st_mid));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_lo == 8'h00 && st_mid == 8'h00 && st_hi == 7'h00 && !nomem_q));

endmodule

// File: tb/err_status_bank_bench.sv
module err_status_bank_bench;
  logic clk = 0, rst = 1;
  logic [7:0] ev_lo = 0, ev_mid = 0;
  logic [6:0] ev_hi = 0;
  logic cfg_err = 0, cfg_nomem = 0, soft_rst = 0, busy_bus = 0, busy_conv = 0;
  logic rd_stb = 0;
  logic [7:0] rd_addr = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  err_status_bank u_err_status_bank (.*);

  // {ev_lo, ev_mid, ev_hi(8b), addr, expected}
  localparam logic [39:0] VEC [11] = '{
    {8'h81, 8'h00, 8'h00, 8'h75, 8'h81},  // R2
    {8'h00, 8'h00, 8'h00, 8'h75, 8'h00},  // R3 cleared
    {8'h00, 8'h3C, 8'h00, 8'h76, 8'h3C},  // R2
    {8'h00, 8'h00, 8'h55, 8'h77, 8'h55},  // R2
    {8'h02, 8'h40, 8'h00, 8'h76, 8'h40},  // R4
    {8'h00, 8'h00, 8'h00, 8'h75, 8'h02},  // R4 untouched
    {8'h00, 8'h00, 8'h00, 8'h78, 8'h00},  // R1
    {8'h10, 8'h00, 8'h00, 8'h74, 8'h00},  // R1
    {8'h00, 8'h00, 8'h00, 8'h75, 8'h10},  // R1 no clear
    {8'h40, 8'h00, 8'h00, 8'h75, 8'h00},  // R7 bit 6 unused
    {8'hFF, 8'hFF, 8'h7F, 8'h76, 8'hFF}   // R2 all
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [7:0] a, logic [7:0] b, logic [6:0] c);
    @(negedge clk); ev_lo = a; ev_mid = b; ev_hi = c;
    @(negedge clk); ev_lo = 0; ev_mid = 0; ev_hi = 0;
  endtask

  task automatic rd(logic [7:0] addr, output logic [7:0] d);
    @(negedge clk); rd_stb = 1; rd_addr = addr;
    @(negedge clk); rd_stb = 0; d = rd_data;
  endtask

  task automatic softr();
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 reset rd_data", rd_data, 8'h00);
    rd(8'h75, got); chk("R10 reset 0x75", got, 8'h00);
    rd(8'h76, got); chk("R10 reset 0x76", got, 8'h00);
    rd(8'h77, got); chk("R10 reset 0x77", got, 8'h00);

    for (int i = 0; i < 11; i++) begin
      pulse(VEC[i][39:32], VEC[i][31:24], VEC[i][22:16]);
      rd(VEC[i][15:8], got);
      chk($sformatf("R1/R2/R4 vector %0d", i), got, VEC[i][7:0]);
    end
    rd(8'h75, got); chk("R2 all 0x75", got, 8'hBF);
    rd(8'h77, got); chk("R2 all 0x77", got, 8'h7F);

    // R3 hold between reads
    pulse(8'h00, 8'h00, 7'h00);
    chk("R3 rd_data holds", rd_data, 8'h7F);

    // R9 live bit, R11 read while busy
    pulse(8'h00, 8'h00, 7'h01);
    busy_bus = 1;
    rd(8'h77, got); chk("R9 R11 busy_bus", got, 8'h81);
    busy_bus = 0; busy_conv = 1;
    rd(8'h77, got); chk("R9 busy_conv, R11 cleared", got, 8'h80);
    busy_conv = 0;
    rd(8'h77, got); chk("R9 not latched", got, 8'h00);

    // R5 event vs read clear
    @(negedge clk); ev_mid = 8'h01; rd_stb = 1; rd_addr = 8'h76;
    @(negedge clk); ev_mid = 0; rd_stb = 0;
    chk("R5 pre-clear value", rd_data, 8'h00);
    rd(8'h76, got); chk("R5 event kept over read", got, 8'h01);

    // R5 event vs soft reset
    @(negedge clk); ev_hi = 7'h01; soft_rst = 1;
    @(negedge clk); ev_hi = 0; soft_rst = 0;
    rd(8'h77, got); chk("R5 event kept over soft reset", got, 8'h01);

    // R6 soft reset clears all
    pulse(8'hA5, 8'h5A, 7'h33);
    softr();
    rd(8'h75, got); chk("R6 0x75", got, 8'h00);
    rd(8'h76, got); chk("R6 0x76", got, 8'h00);
    rd(8'h77, got); chk("R6 0x77", got, 8'h00);

    // R7 checksum cause: cleared by soft reset
    @(negedge clk); cfg_err = 1;
    @(negedge clk); cfg_err = 0;
    softr();
    rd(8'h75, got); chk("R7 checksum error cleared by soft reset", got, 8'h00);

    // R8 missing memory: survives soft reset
    @(negedge clk); cfg_err = 1; cfg_nomem = 1;
    @(negedge clk); cfg_err = 0; cfg_nomem = 0;
    pulse(8'h01, 8'h00, 7'h00);
    softr();
    rd(8'h75, got); chk("R8 bit 6 survives soft reset", got, 8'h40);
    rd(8'h75, got); chk("R8 read clears", got, 8'h00);

    // R10 full reset drops persistence
    @(negedge clk); cfg_err = 1; cfg_nomem = 1;
    @(negedge clk); cfg_err = 0; cfg_nomem = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 rd_data after reset", rd_data, 8'h00);
    rd(8'h75, got); chk("R10 bit 6 cleared by reset", got, 8'h00);
    @(negedge clk); cfg_err = 1;
    @(negedge clk); cfg_err = 0;
    softr();
    rd(8'h75, got); chk("R10 persistence gone after reset", got, 8'h00);

    finish_run();
  end
endmodule